// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of an 8-bit successive-approximation converter that sits on an active-low microprocessor bus. A start strobe (chip select plus write, both low) clears the approximation register and parks the block in a reset state. When either strobe is released, the block waits for the next tick of a free-running bit-clock divider. It then tests one code bit per tick, from the most significant down. It drives each trial code to an external DAC/comparator and reads back a single "input is above trial" bit.

When the last bit is decided, the finished code is copied into an output latch and an active-low interrupt is raised. A read strobe (chip select plus read, both low) enables the latch onto the data bus and clears the interrupt. A new start strobe aborts any conversion in progress. Tying the interrupt back to the write input, with chip select low, makes the block convert continuously.

Top module: `sar_conv_ctrl`

## Requirements
- R1: During and just after synchronous reset, intr_n is 1, dout_oe is 0, dout is 0 and trial_code is 0.
- R2: A divider that runs freely from reset release produces a tick on every 8th clock, namely on the edges where (cycles since reset) mod 8 equals 7. The first tick after the start strobe is released begins the conversion and puts trial_code at 0x80, which gives a start latency of 1 to 8 clocks.
- R3: On each tick of a conversion, the bit under test stays 1 only if cmp_hi is 1, and the next lower bit is set for trial. Between ticks, trial_code does not change.
- R4: The tick that decides bit 0 writes the final code to the output latch and drives intr_n low on the same edge. The edge at which intr_n falls is the 66th to 73rd edge counted from the first edge with the strobe released.
- R5: On every edge where cs_n and wr_n are both low, trial_code is cleared and intr_n is driven high. No conversion progresses for as long as both stay low.
- R6: A start strobe during a conversion aborts it, and the output latch keeps its previous value.
- R7: dout always carries the latch content. dout_oe is 1 in exactly the cycles where cs_n and rd_n are both low.
- R8: A read drives intr_n high on the next edge. If a read and a completion fall on the same edge, the completion wins.
- R9: With cs_n and rd_n held low, the new result appears on dout in the cycle in which intr_n falls.
- R10: With wr_n driven from intr_n and cs_n low, each completion starts the next conversion without outside help.
- R11: Once low, intr_n stays low until a read or a start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Start strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| cmp_hi | input | 1 | Comparator: analog input above trial code |
| trial_code | output | 8 | Code presented to the DAC for comparison |
| dout | output | 8 | Output latch content (bus data) |
| dout_oe | output | 1 | Bus driver enable for dout |
| intr_n | output | 1 | Conversion-done interrupt, active low |

## Verification
On every cycle, the embedded assertions check the following:
- the divider's tick spacing
- that trial_code stays quiet between ticks and starts at 0x80
- that a start strobe forces the reset state and a high interrupt
- that the latch changes only on a completion
- that the interrupt falls only on a completion and holds low until a read or start

Only the bench's scenarios can show:
- the 66 to 73 cycle conversion window measured from the strobe release
- the correct final code for chosen analog values, including 0, 1, 0x80 and 0xFF
- that an aborted conversion leaves the old result
- that free-running operation keeps producing results without a host

// File: rtl/sar_conv_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the conversion sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_conv_pkg;

    // Sequencer state: idle, held in reset, armed for a tick, converting.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RST  = 2'd1,
        ST_WAIT = 2'd2,
        ST_CONV = 2'd3
    } conv_state_t;

endpackage

// File: rtl/sar_conv_timebase.sv
`timescale 1ns/1ps
// Module: free-running bit-clock divider. Emits a one-cycle tick on the
// last phase of every BIT_CLKS-clock period.
// Assumes: BIT_CLKS >= 2; the divider is never restarted by the bus strobes,
// which is what makes the start latency variable.
module sar_conv_timebase #(
    parameter int BIT_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PH_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CLKS - 1);

    logic [PH_W-1:0] phase;

    // Advance the phase counter, wrapping at the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase <= '0;
        else if (phase == PH_LAST) phase <= '0;
        else                       phase <= phase + 1'b1;
    end

    // Decode the tick from the last phase.
    always_comb tick_o = (phase == PH_LAST);

    generate
        if (BIT_CLKS > 1) begin : g_tick_chk
            // R2: two ticks are never adjacent.
            p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/sar_conv_sequencer.sv
`timescale 1ns/1ps
// Module: successive-approximation sequencer. Holds in reset while the
// start strobe is active, arms on release, starts on the next tick and
// resolves one bit per tick from the MSB down.
// Assumes: cmp_hi is valid when a tick edge arrives (the comparator is
// strobed at the end of the bit period); hold outranks everything.
module sar_conv_sequencer
    import sar_conv_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             hold_i,
    input  logic             cmp_hi_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);
    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    conv_state_t      state;
    logic [WIDTH-1:0] sar;
    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] decided;

    // Resolve the bit under test from the comparator.
    always_comb decided = (sar & ~mask) | (cmp_hi_i ? mask : '0);

    // Flag the edge that decides the last bit.
    always_comb done_o = (state == ST_CONV) && tick_i && mask[0] && !hold_i;

    always_comb result_o = decided;
    always_comb trial_o  = sar;

    // State, approximation register and bit pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sar   <= '0;
            mask  <= '0;
        end else if (hold_i) begin
            state <= ST_RST;
            sar   <= '0;
            mask  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_RST:  state <= ST_WAIT;
                ST_WAIT: begin
                    if (tick_i) begin
                        state <= ST_CONV;
                        sar   <= TOP_BIT;
                        mask  <= TOP_BIT;
                    end
                end
                ST_CONV: begin
                    if (tick_i) begin
                        if (mask[0]) begin
                            sar   <= decided;
                            mask  <= '0;
                            state <= ST_IDLE;
                        end else begin
                            sar  <= decided | (mask >> 1);
                            mask <= mask >> 1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: a held strobe parks the sequencer with a cleared code.
    p_held_in_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (state == ST_RST && trial_o == '0));
    // R2: an armed sequencer starts with only the MSB on trial.
    p_start_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && tick_i && !hold_i) |=> (trial_o == TOP_BIT));
    // R3: the trial code moves only on ticks or strobes.
    p_quiet_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !hold_i && state != ST_RST) |=> $stable(trial_o));
    // R3: at most one bit is under test.
    p_single_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask));
endmodule

// File: rtl/sar_conv_busif.sv
`timescale 1ns/1ps
// Module: bus side. Decodes the active-low strobes, keeps the output latch
// and the interrupt flag, and drives the output enable.
// Assumes: strobes are synchronous to clk; done_i is only high on an edge
// where no start strobe is active.
module sar_conv_busif #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             done_i,
    input  logic [WIDTH-1:0] result_i,
    output logic             hold_o,
    output logic [WIDTH-1:0] dout_o,
    output logic             dout_oe_o,
    output logic             intr_n_o
);
    logic read;

    // Decode start-hold and read from the strobes.
    always_comb begin
        hold_o    = !cs_n && !wr_n;
        read      = !cs_n && !rd_n;
        dout_oe_o = read;
    end

    // Capture a finished code; nothing else writes the latch.
    always_ff @(posedge clk) begin
        if (!rst_n)      dout_o <= '0;
        else if (done_i) dout_o <= result_i;
    end

    // Interrupt flag: start strobe sets high, completion low, read high.
    always_ff @(posedge clk) begin
        if (!rst_n)      intr_n_o <= 1'b1;
        else if (hold_o) intr_n_o <= 1'b1;
        else if (done_i) intr_n_o <= 1'b0;
        else if (read)   intr_n_o <= 1'b1;
    end

    // R6: the latch holds unless a conversion completes.
    p_latch_only_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(dout_o));
    // R4: the interrupt falls only on a completion edge.
    p_intr_fall_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_n_o) |-> $past(done_i));
    // R5: a start strobe releases the interrupt.
    p_hold_releases_intr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> intr_n_o);
    // R8: a read without a completion releases the interrupt.
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (read && !done_i) |=> intr_n_o);
    // R11: with no read and no strobe, a pending interrupt stays low.
    p_intr_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!intr_n_o && !hold_o && !read) |=> !intr_n_o);
endmodule

// File: rtl/sar_conv_ctrl.sv
`timescale 1ns/1ps
// Module: top of the conversion sequencer. Connects the bit-clock divider,
// the approximation sequencer and the bus side.
// Assumes: analog comparator, DAC and tri-state pads are outside; the
// tri-state bus is represented by dout plus dout_oe.
module sar_conv_ctrl #(
    parameter int WIDTH    = 8,
    parameter int BIT_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial_code,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             intr_n
);
    logic             tick;
    logic             hold;
    logic             done;
    logic [WIDTH-1:0] result;

    sar_conv_timebase #(.BIT_CLKS(BIT_CLKS)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    sar_conv_sequencer #(.WIDTH(WIDTH)) u_sequencer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .hold_i   (hold),
        .cmp_hi_i (cmp_hi),
        .trial_o  (trial_code),
        .done_o   (done),
        .result_o (result)
    );

    sar_conv_busif #(.WIDTH(WIDTH)) u_busif (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .done_i    (done),
        .result_i  (result),
        .hold_o    (hold),
        .dout_o    (dout),
        .dout_oe_o (dout_oe),
        .intr_n_o  (intr_n)
    );
endmodule

// File: tb/sar_conv_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle reference model plus directed scenarios.
module sar_conv_ctrl_bench;
    localparam int W  = 8;
    localparam int BC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic wr_q = 1'b1;
    logic rd_n = 1'b1;
    logic fr = 1'b0;
    logic [W-1:0] ain = '0;
    logic [W-1:0] trial_code;
    logic [W-1:0] dout;
    logic dout_oe;
    logic intr_n;
    logic wr_n;
    logic cmp_hi;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Reference model state.
    int m_phase = 0, m_st = 0, m_code = 0, m_bit = 0, m_latch = 0, m_intr = 1;

    assign wr_n   = fr ? (intr_n & wr_q) : wr_q;
    assign cmp_hi = (ain > trial_code);

    sar_conv_ctrl #(.WIDTH(W), .BIT_CLKS(BC)) u_sar_conv_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cmp_hi(cmp_hi), .trial_code(trial_code), .dout(dout),
        .dout_oe(dout_oe), .intr_n(intr_n)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int expect_code(input int a);
        int c = 0;
        for (int b = W - 1; b >= 0; b--) begin
            if (a > (c | (1 << b))) c = c | (1 << b);
        end
        return c;
    endfunction

    // Reference model: one step per clock edge.
    always @(posedge clk) begin
        bit tick, hold, rd, done;
        if (!rst_n) begin
            m_phase = 0; m_st = 0; m_code = 0; m_bit = 0; m_latch = 0; m_intr = 1;
        end else begin
            tick = (m_phase == BC - 1);
            m_phase = (m_phase + 1) % BC;
            hold = !cs_n && !wr_n;
            rd   = !cs_n && !rd_n;
            done = 0;
            if (hold) begin
                m_st = 1; m_code = 0;
            end else begin
                case (m_st)
                    1: m_st = 2;
                    2: if (tick) begin m_st = 3; m_bit = W - 1; m_code = 1 << (W - 1); end
                    3: if (tick) begin
                        if (!(ain > m_code)) m_code = m_code & ~(1 << m_bit);
                        if (m_bit == 0) begin m_latch = m_code; m_st = 0; done = 1; end
                        else begin m_bit--; m_code = m_code | (1 << m_bit); end
                    end
                    default: ;
                endcase
            end
            if (hold)      m_intr = 1;
            else if (done) m_intr = 0;
            else if (rd)   m_intr = 1;
        end
    end

    // Compare against the model away from the edge, every cycle.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            chk("R3 trial_code", trial_code, m_code);
            chk("R4 intr_n", intr_n, m_intr);
            chk("R7 dout", dout, m_latch);
            chk("R7 dout_oe", dout_oe, (!cs_n && !rd_n) ? 1 : 0);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic pulse_start(input int len);
        @(negedge clk); cs_n = 1'b0; wr_q = 1'b0;
        repeat (len) @(negedge clk);
        wr_q = 1'b1; cs_n = 1'b1;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(posedge clk); #2; n++;
            if (!intr_n) break;
        end
    endtask

    task automatic read_and_check(input int exp, input string tag);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
        chk("R7 oe during read", dout_oe, 1);
        chk(tag, dout, exp);
        @(posedge clk); #2;
        chk("R8 intr_n after read", intr_n, 1);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic convert(input int a, input string tag);
        int n;
        ain = W'(a);
        pulse_start(2);
        wait_done(n);
        checks++;
        if (n < 66 || n > 73) begin
            errors++;
            $display("FAIL R2/R4 latency: actual %0d expected 66..73", n);
        end
        read_and_check(expect_code(a), tag);
    endtask

    initial begin
        int n, falls, prev;
        repeat (4) @(posedge clk);
        #2;
        chk("R1 intr_n reset", intr_n, 1);
        chk("R1 dout_oe reset", dout_oe, 0);
        chk("R1 dout reset", dout, 0);
        chk("R1 trial reset", trial_code, 0);
        @(negedge clk); rst_n = 1'b1;

        convert(8'hA5, "R3 code A5");
        convert(0,     "R3 code 00");
        convert(8'hFF, "R3 code FF");
        convert(8'h80, "R3 code 80");
        convert(1,     "R3 code 01");

        // R11: pending interrupt stays low without a read.
        ain = 8'h3C; pulse_start(1); wait_done(n);
        repeat (20) @(negedge clk);
        chk("R11 intr_n held", intr_n, 0);
        read_and_check(expect_code(8'h3C), "R11 code 3C");

        // R6 and R5: abort mid-conversion, long strobe hold.
        prev = expect_code(8'h3C);
        ain = 8'h33; pulse_start(2);
        repeat (30) @(negedge clk);
        @(negedge clk); cs_n = 1'b0; wr_q = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(posedge clk); #2;
            chk("R5 intr_n held high", intr_n, 1);
            chk("R5 trial cleared", trial_code, 0);
        end
        ain = 8'h5A;
        @(negedge clk); wr_q = 1'b1; cs_n = 1'b1;
        repeat (10) @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; #1;
        chk("R6 latch kept after abort", dout, prev);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        wait_done(n);
        chk("R6 completes after restart", intr_n, 0);
        read_and_check(expect_code(8'h5A), "R6 code 5A");

        // R9 and R8: read held low across a conversion.
        ain = 8'hC3;
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; wr_q = 1'b0;
        @(negedge clk); @(negedge clk); wr_q = 1'b1;
        wait_done(n);
        chk("R9 dout at completion", dout, expect_code(8'hC3));
        @(posedge clk); #2;
        chk("R8 read clears next edge", intr_n, 1);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;

        // R10: free-running with wr_n tied to intr_n.
        ain = 8'h6C;
        @(negedge clk); fr = 1'b1; cs_n = 1'b0; wr_q = 1'b0;
        @(negedge clk); wr_q = 1'b1;
        falls = 0;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #2;
            if (!intr_n) falls++;
        end
        checks++;
        if (falls < 5) begin
            errors++;
            $display("FAIL R10 free-run completions: actual %0d expected >= 5", falls);
        end
        chk("R10 free-run result", dout, expect_code(8'h6C));
        @(negedge clk); fr = 1'b0; cs_n = 1'b1;
        repeat (100) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule